// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Tag Controller

This block holds the tags and valid bits of a small four-way set-associative read cache. A lookup presents an address and a request class (instruction or data). One cycle later the block reports whether the line is present and which way holds it. On a miss that may be cached, the block chooses a victim way in the same cycle and records the new tag there. It also reports that way, so that the surrounding logic knows where to place the refilled data. The data array, the memory refill and any register decoding sit outside this block.

The default geometry is 4 KB of capacity in 16-byte lines over four ways. That gives 64 sets. Victims are picked round-robin from a single pointer, and any way flagged in a per-way lock mask is skipped. Two maintenance operations are provided. A sweep clears every valid bit at one set per cycle and holds a busy flag while it runs. A single-line clear takes a set index and a way number.

Caching as a whole is gated by a global enable, which is off after reset. Instruction requests and data requests can each be turned off on their own. A request that is not allowed to use the cache always misses and never records a tag.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The address splits into a byte offset in bits [3:0], a set index in bits [9:4] and a tag in bits [31:10]. A recorded line hits for every address with the same tag and index, whatever the offset. An address with the same index and a different tag misses.
- R2: Every cycle with `lk_valid_i` high produces `rsp_valid_o` high on the next cycle, and `rsp_valid_o` is low otherwise. A hit sets `rsp_hit_o` and gives the hitting way (0 to 3) on `rsp_way_o`. `rsp_hit_o` and `rsp_fill_o` are never high together. A response with neither flag set gives way 0.
- R3: A cacheable miss records its tag in a victim way and reports it with `rsp_fill_o` high and the way on `rsp_way_o`. The victim is the first unlocked way found by counting upward, with wrap-around, from a replacement pointer. The pointer is 0 after reset and moves to victim+1 (mod 4) after each fill. It does not move otherwise.
- R4: `lock_i` bit w set means that way w is never chosen as a victim. When all four bits are set, a miss records nothing and `rsp_fill_o` stays low.
- R5: A pulse on `inv_all_i` raises `busy_o` on the next cycle and keeps it high for exactly 64 cycles while every set is cleared. A lookup issued while `busy_o` is high, or in the same cycle as `inv_all_i`, misses and records nothing. After the sweep, every earlier line misses.
- R6: `inv_line_i` clears the valid bit of the line at set `inv_set_i[5:0]` in way `inv_way_i`. Bits [7:6] of `inv_set_i` are ignored. The other ways of that set keep their lines.
- R7: `active_o` is 0 after reset and follows `enable_i` one cycle later. While `active_o` is 0, every lookup misses and records nothing.
- R8: `lk_is_data_i` = 1 marks a data request and 0 marks an instruction request. While `data_off_i` is high, data requests miss and record nothing. While `instr_off_i` is high, instruction requests do the same. The other class is unaffected in both cases.
- R9: A lookup in the cycle right after a fill, to the same line, hits in the way just filled.
- R10: When a single-line clear and a fill land on the same line in the same cycle, the clear wins: the fill is still reported, but the next lookup of that line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global cache enable |
| active_o | output | 1 | Cache is active (registered enable) |
| instr_off_i | input | 1 | Turns off caching of instruction requests |
| data_off_i | input | 1 | Turns off caching of data requests |
| lock_i | input | 4 | One bit per way; a set bit keeps that way from replacement |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_addr_i | input | 32 | Lookup byte address |
| lk_is_data_i | input | 1 | Request class: 1 data, 0 instruction |
| rsp_valid_o | output | 1 | Response for the previous cycle's lookup |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_fill_o | output | 1 | Miss that recorded a new tag |
| rsp_way_o | output | 2 | Hitting or filled way |
| inv_all_i | input | 1 | Start the invalidate-all sweep |
| busy_o | output | 1 | Sweep in progress |
| inv_line_i | input | 1 | Clear a single line |
| inv_set_i | input | 8 | Set index for the single-line clear (low 6 bits used) |
| inv_way_i | input | 2 | Way for the single-line clear |

## Verification
The checker assumes that every control input is a known 0 or 1 once reset is released. It also assumes that `inv_all_i` is raised only while `busy_o` is low, because the busy-length property counts from a single start. The bench drives every input on the falling edge, issues one operation per task, and starts each sweep only after the previous one has ended. A lock mask of all ones is applied only across lookups that are expected to record nothing.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

   typedef enum logic {
      REQ_INSTR = 1'b0,
      REQ_DATA  = 1'b1
   } req_class_e;

   function automatic int sets_of(input int cap_bytes, input int line_bytes, input int ways);
      return cap_bytes / (line_bytes * ways);
   endfunction

endpackage

// File: rtl/cache_tag_way.sv
module cache_tag_way #(
   parameter int SETS  = 64,
   parameter int TAG_W = 22,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] look_idx,
   input  logic [TAG_W-1:0] look_tag,
   output logic             hit_o,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             kill_en,
   input  logic [IDX_W-1:0] kill_idx,
   input  logic             sweep_en,
   input  logic [IDX_W-1:0] sweep_idx
);

   logic [TAG_W-1:0] tag_q [SETS];
   logic [SETS-1:0]  vld_q;

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[fill_idx] <= fill_tag;
   end

   // later statements take priority: a clear beats a fill on the same line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (fill_en)  vld_q[fill_idx]  <= 1'b1;
         if (kill_en)  vld_q[kill_idx]  <= 1'b0;
         if (sweep_en) vld_q[sweep_idx] <= 1'b0;
      end
   end

   assign hit_o = vld_q[look_idx] && (tag_q[look_idx] == look_tag);

endmodule

// File: rtl/cache_tag_victim.sv
module cache_tag_victim #(
   parameter int WAYS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [WAYS-1:0]         lock_i,
   input  logic                    adv_i,
   output logic [$clog2(WAYS)-1:0] victim_o,
   output logic                    found_o,
   output logic [$clog2(WAYS)-1:0] ptr_o
);

   localparam int WAY_W = $clog2(WAYS);

   logic [WAY_W-1:0] ptr_q;
   logic [WAY_W-1:0] cand;

   // walk downward so that the smallest distance from the pointer wins
   always_comb begin
      found_o  = 1'b0;
      victim_o = ptr_q;
      cand     = ptr_q;
      for (int k = WAYS - 1; k >= 0; k--) begin
         cand = ptr_q + WAY_W'(k);
         if (!lock_i[cand]) begin
            found_o  = 1'b1;
            victim_o = cand;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '0;
      else if (adv_i) ptr_q <= victim_o + 1'b1;
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/cache_tag_sweep.sv
module cache_tag_sweep #(
   parameter int SETS  = 64,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             busy_o,
   output logic [IDX_W-1:0] idx_o
);

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end
      end else begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == IDX_W'(SETS - 1)) busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign idx_o  = idx_q;

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
   import cache_tag_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CAP_BYTES   = 4096,
   parameter int LINE_BYTES  = 16,
   parameter int WAYS        = 4,
   parameter int MAINT_IDX_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable_i,
   output logic                    active_o,
   input  logic                    instr_off_i,
   input  logic                    data_off_i,
   input  logic [WAYS-1:0]         lock_i,
   input  logic                    lk_valid_i,
   input  logic [ADDR_W-1:0]       lk_addr_i,
   input  logic                    lk_is_data_i,
   output logic                    rsp_valid_o,
   output logic                    rsp_hit_o,
   output logic                    rsp_fill_o,
   output logic [$clog2(WAYS)-1:0] rsp_way_o,
   input  logic                    inv_all_i,
   output logic                    busy_o,
   input  logic                    inv_line_i,
   input  logic [MAINT_IDX_W-1:0]  inv_set_i,
   input  logic [$clog2(WAYS)-1:0] inv_way_i
);

   localparam int SETS  = sets_of(CAP_BYTES, LINE_BYTES, WAYS);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
   localparam int WAY_W = $clog2(WAYS);

   initial begin
      assert (WAYS >= 2 && (WAYS & (WAYS - 1)) == 0)
         else $error("WAYS must be a power of two, at least 2");
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0 && SETS * LINE_BYTES * WAYS == CAP_BYTES)
         else $error("capacity must split into a power-of-two number of sets");
      assert (MAINT_IDX_W >= IDX_W) else $error("maintenance index too narrow");
      assert (TAG_W > 0) else $error("address too narrow for geometry");
   end

   logic             en_q;
   logic             sweep_busy;
   logic [IDX_W-1:0] sweep_idx;
   logic [IDX_W-1:0] look_idx;
   logic [TAG_W-1:0] look_tag;
   logic [WAYS-1:0]  way_hit;
   logic [WAY_W-1:0] hit_way;
   logic [WAY_W-1:0] victim_w;
   logic [WAY_W-1:0] rr_ptr_w;
   logic             victim_found;
   logic             class_off;
   logic             cacheable;
   logic             hit_w;
   logic             alloc_w;
   req_class_e       req_class;
   logic             unused_bits;

   assign look_idx  = lk_addr_i[OFF_W +: IDX_W];
   assign look_tag  = lk_addr_i[ADDR_W-1 -: TAG_W];
   assign req_class = req_class_e'(lk_is_data_i);
   assign class_off = (req_class == REQ_DATA) ? data_off_i : instr_off_i;
   assign cacheable = lk_valid_i && en_q && !class_off && !sweep_busy && !inv_all_i;
   assign hit_w     = cacheable && (|way_hit);
   assign alloc_w   = cacheable && !(|way_hit) && victim_found;

   if (MAINT_IDX_W > IDX_W) begin : g_wide_maint
      assign unused_bits = ^{lk_addr_i[OFF_W-1:0], inv_set_i[MAINT_IDX_W-1:IDX_W]};
   end else begin : g_exact_maint
      assign unused_bits = ^lk_addr_i[OFF_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= enable_i;
   end

   cache_tag_sweep #(.SETS(SETS), .IDX_W(IDX_W)) u_sweep (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (inv_all_i),
      .busy_o  (sweep_busy),
      .idx_o   (sweep_idx)
   );

   cache_tag_victim #(.WAYS(WAYS)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_i   (lock_i),
      .adv_i    (alloc_w),
      .victim_o (victim_w),
      .found_o  (victim_found),
      .ptr_o    (rr_ptr_w)
   );

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      cache_tag_way #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_way (
         .clk       (clk),
         .rst_n     (rst_n),
         .look_idx  (look_idx),
         .look_tag  (look_tag),
         .hit_o     (way_hit[w]),
         .fill_en   (alloc_w && (victim_w == WAY_W'(w))),
         .fill_idx  (look_idx),
         .fill_tag  (look_tag),
         .kill_en   (inv_line_i && (inv_way_i == WAY_W'(w))),
         .kill_idx  (inv_set_i[IDX_W-1:0]),
         .sweep_en  (sweep_busy),
         .sweep_idx (sweep_idx)
      );
   end

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (way_hit[w]) hit_way = WAY_W'(w);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_hit_o   <= 1'b0;
         rsp_fill_o  <= 1'b0;
         rsp_way_o   <= '0;
      end else begin
         rsp_valid_o <= lk_valid_i;
         rsp_hit_o   <= hit_w;
         rsp_fill_o  <= alloc_w;
         rsp_way_o   <= hit_w ? hit_way : (alloc_w ? victim_w : '0);
      end
   end

   assign active_o = en_q;
   assign busy_o   = sweep_busy;

endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
   parameter int WAYS = 4,
   parameter int SETS = 64
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    enable_i,
   input logic                    active_o,
   input logic                    instr_off_i,
   input logic                    data_off_i,
   input logic [WAYS-1:0]         lock_i,
   input logic                    lk_valid_i,
   input logic                    lk_is_data_i,
   input logic                    rsp_valid_o,
   input logic                    rsp_hit_o,
   input logic                    rsp_fill_o,
   input logic                    busy_o,
   input logic                    alloc,
   input logic [$clog2(WAYS)-1:0] victim,
   input logic [$clog2(WAYS)-1:0] ptr
);

   localparam int WAY_W = $clog2(WAYS);

   logic [31:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_run <= '0;
      else if (!busy_o) busy_run <= '0;
      else              busy_run <= busy_run + 1'b1;
   end

   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid_i |=> rsp_valid_o);
   assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid_i |=> !rsp_valid_o);
   assert_hit_fill_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit_o && rsp_fill_o));
   assert_rr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |=> ptr == WAY_W'($past(victim) + 1'b1));
   assert_rr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc |=> $stable(ptr));
   assert_fill_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !lock_i[victim]);
   assert_all_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid_i && (&lock_i)) |=> !rsp_fill_o);
   assert_busy_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && lk_valid_i) |=> (!rsp_hit_o && !rsp_fill_o));
   assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> busy_run < 32'(SETS));
   assert_on_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enable_i) |=> active_o);
   assert_off_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(enable_i) |=> !active_o);
   assert_inactive_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && lk_valid_i) |=> (!rsp_hit_o && !rsp_fill_o));
   assert_class_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid_i && (lk_is_data_i ? data_off_i : instr_off_i)) |=> (!rsp_hit_o && !rsp_fill_o));

endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable_i     (enable_i),
   .active_o     (active_o),
   .instr_off_i  (instr_off_i),
   .data_off_i   (data_off_i),
   .lock_i       (lock_i),
   .lk_valid_i   (lk_valid_i),
   .lk_is_data_i (lk_is_data_i),
   .rsp_valid_o  (rsp_valid_o),
   .rsp_hit_o    (rsp_hit_o),
   .rsp_fill_o   (rsp_fill_o),
   .busy_o       (busy_o),
   .alloc        (alloc_w),
   .victim       (victim_w),
   .ptr          (rr_ptr_w)
);

// File: tb/tb_cache_tag_ctrl.sv
module tb_cache_tag_ctrl;

   localparam int SETS = 64;
   localparam int WAYS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable_i = 1'b0;
   logic        instr_off_i = 1'b0;
   logic        data_off_i = 1'b0;
   logic [3:0]  lock_i = '0;
   logic        lk_valid_i = 1'b0;
   logic [31:0] lk_addr_i = '0;
   logic        lk_is_data_i = 1'b0;
   logic        inv_all_i = 1'b0;
   logic        inv_line_i = 1'b0;
   logic [7:0]  inv_set_i = '0;
   logic [1:0]  inv_way_i = '0;
   logic        active_o, rsp_valid_o, rsp_hit_o, rsp_fill_o, busy_o;
   logic [1:0]  rsp_way_o;

   always #5 clk = ~clk;

   cache_tag_ctrl dut (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .active_o(active_o),
      .instr_off_i(instr_off_i), .data_off_i(data_off_i), .lock_i(lock_i),
      .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_is_data_i(lk_is_data_i),
      .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_fill_o(rsp_fill_o),
      .rsp_way_o(rsp_way_o), .inv_all_i(inv_all_i), .busy_o(busy_o),
      .inv_line_i(inv_line_i), .inv_set_i(inv_set_i), .inv_way_i(inv_way_i)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model of the tag store
   logic [21:0] m_tag [SETS][WAYS];
   bit          m_val [SETS][WAYS];
   int          m_rr = 0;
   bit          m_en = 1'b0;
   bit          m_busy = 1'b0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int tag, input int set, input int off);
      return {22'(tag), 6'(set), 4'(off)};
   endfunction

   function automatic int tagf(input int s, input int k);
      return s * 13 + k * 1000 + 5;
   endfunction

   // entered and left at a falling edge
   task automatic do_lookup(input logic [31:0] addr, input bit is_data, input string req,
                            input bit kill = 1'b0, input int kill_way = 0);
      int s;
      logic [21:0] t;
      bit ok, ehit, efill, cls_off;
      int eway;
      s = int'(addr[9:4]);
      t = addr[31:10];
      cls_off = is_data ? data_off_i : instr_off_i;
      ok = m_en && !cls_off && !m_busy;
      ehit = 1'b0; efill = 1'b0; eway = 0;
      if (ok) begin
         for (int w = 0; w < WAYS; w++)
            if (m_val[s][w] && m_tag[s][w] == t) begin ehit = 1'b1; eway = w; end
         if (!ehit) begin
            for (int k = WAYS - 1; k >= 0; k--)
               if (!lock_i[(m_rr + k) % WAYS]) begin efill = 1'b1; eway = (m_rr + k) % WAYS; end
         end
      end
      lk_valid_i = 1'b1; lk_addr_i = addr; lk_is_data_i = is_data;
      if (kill) begin
         inv_line_i = 1'b1; inv_set_i = 8'(s); inv_way_i = 2'(kill_way);
      end
      @(posedge clk);
      if (efill) begin
         m_tag[s][eway] = t; m_val[s][eway] = 1'b1; m_rr = (eway + 1) % WAYS;
      end
      if (kill) m_val[s][kill_way] = 1'b0;
      @(negedge clk);
      lk_valid_i = 1'b0; inv_line_i = 1'b0;
      chk(req, "rsp_valid", rsp_valid_o, 1);
      chk(req, "hit", rsp_hit_o, ehit);
      chk(req, "fill", rsp_fill_o, efill);
      chk(req, "way", rsp_way_o, eway);
   endtask

   task automatic inv_one(input logic [7:0] raw_set, input int way);
      inv_line_i = 1'b1; inv_set_i = raw_set; inv_way_i = 2'(way);
      @(posedge clk);
      m_val[raw_set[5:0]][way] = 1'b0;
      @(negedge clk);
      inv_line_i = 1'b0;
   endtask

   function automatic int way_of(input int s, input int tag);
      int r = -1;
      for (int w = 0; w < WAYS; w++) if (m_val[s][w] && m_tag[s][w] == 22'(tag)) r = w;
      return r;
   endfunction

   initial begin
      int busy_cnt;
      int v;
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_val[s][w] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R7", "active after reset", active_o, 0);
      chk("R5", "busy after reset", busy_o, 0);
      chk("R2", "rsp_valid after reset", rsp_valid_o, 0);

      // R7: inactive cache never hits or fills
      do_lookup(mk(7, 3, 0), 1'b0, "R7 inactive");
      enable_i = 1'b1;
      @(negedge clk);
      chk("R7", "active after enable", active_o, 1);
      m_en = 1'b1;

      // R3: fill every way of every set
      for (int s = 0; s < SETS; s++)
         for (int k = 0; k < WAYS; k++)
            do_lookup(mk(tagf(s, k), s, (s + k) % 16), k[0], "R3 fill sweep");
      // R1/R2: every line hits with another offset
      for (int s = 0; s < SETS; s++)
         for (int k = 0; k < WAYS; k++)
            do_lookup(mk(tagf(s, k), s, 15 - ((s + k) % 16)), ~k[0], "R1 R2 hit sweep");

      // R1: differing tag misses; R9: back-to-back hit after fill
      do_lookup(mk(999, 3, 2), 1'b1, "R1 tag mismatch");
      do_lookup(mk(999, 3, 9), 1'b0, "R9 back-to-back");

      // R4: locked ways skipped
      lock_i = 4'b0101;
      for (int k = 0; k < 4; k++) do_lookup(mk(2000 + k, 10, 0), 1'b0, "R4 partial lock");
      lock_i = 4'b1111;
      do_lookup(mk(3000, 11, 0), 1'b1, "R4 all locked");
      do_lookup(mk(3000, 11, 4), 1'b1, "R4 all locked nothing recorded");
      lock_i = 4'b0000;

      // R8: class disables
      data_off_i = 1'b1;
      do_lookup(mk(tagf(12, 0), 12, 0), 1'b1, "R8 data off");
      do_lookup(mk(tagf(12, 1), 12, 0), 1'b0, "R8 instr unaffected");
      data_off_i = 1'b0; instr_off_i = 1'b1;
      do_lookup(mk(tagf(12, 2), 12, 0), 1'b0, "R8 instr off");
      do_lookup(mk(tagf(12, 3), 12, 0), 1'b1, "R8 data unaffected");
      instr_off_i = 1'b0;

      // R6: single-line clear, upper index bits ignored
      v = way_of(20, tagf(20, 2));
      chk("R6", "model holds line", (v >= 0) ? 1 : 0, 1);
      inv_one(8'hC0 | 8'd20, (v >= 0) ? v : 0);
      for (int k = 0; k < 4; k++) if (k != 2) do_lookup(mk(tagf(20, k), 20, 1), 1'b0, "R6 others kept");
      do_lookup(mk(tagf(20, 2), 20, 1), 1'b0, "R6 cleared line misses");

      // R10: clear and fill on the same line
      v = m_rr;
      do_lookup(mk(4444, 30, 0), 1'b1, "R10 fill with clear", 1'b1, v);
      do_lookup(mk(4444, 30, 0), 1'b1, "R10 clear wins");

      // R5: invalidate-all sweep
      inv_all_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      inv_all_i = 1'b0;
      chk("R5", "busy after start", busy_o, 1);
      busy_cnt = 1;
      m_busy = 1'b1;
      do_lookup(mk(tagf(40, 0), 40, 0), 1'b0, "R5 lookup while busy");
      if (busy_o) busy_cnt++;
      while (busy_o && busy_cnt < 1000) begin
         @(negedge clk);
         if (busy_o) busy_cnt++;
      end
      chk("R5", "busy length", busy_cnt, SETS);
      m_busy = 1'b0;
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_val[s][w] = 1'b0;
      do_lookup(mk(tagf(0, 1), 0, 0), 1'b0, "R5 after sweep");
      do_lookup(mk(tagf(17, 3), 17, 0), 1'b1, "R5 after sweep");
      do_lookup(mk(tagf(63, 0), 63, 0), 1'b0, "R5 after sweep");

      // R7: disable again
      enable_i = 1'b0;
      @(negedge clk);
      chk("R7", "active after disable", active_o, 0);
      m_en = 1'b0;
      do_lookup(mk(tagf(63, 0), 63, 0), 1'b0, "R7 disabled");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule